// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

In a core that runs several hardware threads out of order, only one thread's reorder-buffer head can retire in each commit slot. This block decides which thread that is. Each thread supplies an active bit, a 3-bit state code, a buffer-empty flag, a head-ready flag and the sequence number of its head entry. A static policy input picks one of three schemes. The block returns a valid bit and a thread index from combinational logic. A grant strobe tells the block that the commit logic used the offered pick, and that strobe is the only input that changes the block's internal state.

The pick and the grant form a valid/ready pair. `pick_valid` offers a thread and `grant` accepts it. A grant while `pick_valid` is low means nothing. The pick need not stay stable while it is not granted: it follows the inputs in the same cycle. The commit logic may ask again for each slot of a cycle. Only the rotating policy keeps state. It holds an ordered list of thread indices, and a granted thread moves to the tail of that list on the next clock edge.

Top module: `smt_commit_arbiter`

## Requirements
- R1: `policy_sel` encodes 0 = greedy, 1 = rotating, 2 = oldest-first, and 3 is treated as oldest-first. Greedy gives exactly the same pick as oldest-first.
- R2: State codes 0 (running), 1 (idle) and 2 (waiting on a fetch-side trap) allow a thread to be picked. Codes 3 (trap pending), 4 (buffer flushing), 5 (flush-after pending), 6 and 7 never allow it.
- R3: A thread whose `thr_active` bit is low is never picked.
- R4: In oldest-first and greedy modes, a thread qualifies only when it is active, has an allowed state, has `rob_empty` low and has `head_ready` high. Among the qualifying threads, the one with the smallest head sequence number is picked (unsigned compare).
- R5: When two threads tie on sequence number in oldest-first or greedy mode, the lower thread index wins.
- R6: In rotating mode, the priority list resets to ascending index order (0 first). The pick is the first thread in list order that is active, has an allowed state and has `head_ready` high. `rob_empty` is not consulted in this mode.
- R7: On the clock edge after `grant` is seen with `pick_valid` high in rotating mode, the picked thread moves to the tail of the list and the other threads keep their relative order. A grant with `pick_valid` low, or a grant in any other mode, leaves the list unchanged.
- R8: When no thread qualifies, `pick_valid` is 0 and `pick_tid` is 0.
- R9: With `NUM_THREADS` = 1, thread 0 is picked whenever it is active and its state is allowed, whatever its ready flag, empty flag and the policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 2 | Selection scheme (R1) |
| thr_active | input | NUM_THREADS | Per-thread active bit |
| thr_status | input | 3*NUM_THREADS | Per-thread state code, thread t at bits [3t+2:3t] |
| rob_empty | input | NUM_THREADS | Per-thread reorder buffer empty |
| head_ready | input | NUM_THREADS | Per-thread head entry ready to retire |
| head_seq | input | SEQ_W*NUM_THREADS | Per-thread head sequence number, thread t at [SEQ_W*t +: SEQ_W] |
| grant | input | 1 | Commit logic accepts the current pick |
| pick_valid | output | 1 | A thread is offered |
| pick_tid | output | TID_W | Index of the offered thread |

## Verification
A corrupted priority list is the only hidden state this block has. It shows up as a wrong `pick_tid` on the first rotating-mode request after the damage, in the same cycle as that request. For that reason the rotation model is compared after every grant while the inputs vary heavily from cycle to cycle. Faults in the eligibility or sequence-compare logic have no memory, so they show up in the very cycle the offending inputs appear. The sweep covers random states, ties and empty flags under all four policy codes.

// File: rtl/smt_commit_pkg.sv
package smt_commit_pkg;
  typedef enum logic [2:0] {
    TS_RUNNING     = 3'd0,
    TS_IDLE        = 3'd1,
    TS_FETCH_TRAP  = 3'd2,
    TS_TRAP_WAIT   = 3'd3,
    TS_ROB_FLUSH   = 3'd4,
    TS_FLUSH_AFTER = 3'd5
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_OLDEST = 2'd2
  } commit_pol_e;

  // States from which a thread may be offered for retirement (R2)
  function automatic logic state_allows(input logic [2:0] s);
    return (s == TS_RUNNING) || (s == TS_IDLE) || (s == TS_FETCH_TRAP);
  endfunction
endpackage

// File: rtl/commit_elig.sv
module commit_elig
  import smt_commit_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0]   thr_active,
  input  logic [3*NUM_THREADS-1:0] thr_status,
  output logic [NUM_THREADS-1:0]   base_ok
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign base_ok[t] = thr_active[t] & state_allows(thr_status[3*t +: 3]);
  end
endmodule

// File: rtl/commit_rr_pick.sv
module commit_rr_pick #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] qual,
  input  logic                   advance,
  output logic                   valid,
  output logic [TID_W-1:0]       tid
);
  logic [TID_W-1:0] order_q [NUM_THREADS];
  logic [TID_W-1:0] hit_pos;

  always_comb begin
    valid   = 1'b0;
    tid     = '0;
    hit_pos = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (!valid && qual[order_q[i]]) begin
        valid   = 1'b1;
        tid     = order_q[i];
        hit_pos = TID_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= TID_W'(i);
    end else if (advance && valid) begin
      for (int i = 0; i < NUM_THREADS - 1; i++) begin
        if (TID_W'(i) >= hit_pos) order_q[i] <= order_q[i+1];
      end
      order_q[NUM_THREADS-1] <= tid;
    end
  end
endmodule

// File: rtl/commit_age_pick.sv
module commit_age_pick #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0]       qual,
  input  logic [SEQ_W*NUM_THREADS-1:0] head_seq,
  output logic                         valid,
  output logic [TID_W-1:0]             tid
);
  logic [SEQ_W-1:0] best;

  // Strict compare keeps the lower index on ties (R5)
  always_comb begin
    valid = 1'b0;
    tid   = '0;
    best  = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (qual[t] && (!valid || head_seq[SEQ_W*t +: SEQ_W] < best)) begin
        valid = 1'b1;
        tid   = TID_W'(t);
        best  = head_seq[SEQ_W*t +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/smt_commit_arbiter.sv
module smt_commit_arbiter
  import smt_commit_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   policy_sel,
  input  logic [NUM_THREADS-1:0]       thr_active,
  input  logic [3*NUM_THREADS-1:0]     thr_status,
  input  logic [NUM_THREADS-1:0]       rob_empty,
  input  logic [NUM_THREADS-1:0]       head_ready,
  input  logic [SEQ_W*NUM_THREADS-1:0] head_seq,
  input  logic                         grant,
  output logic                         pick_valid,
  output logic [TID_W-1:0]             pick_tid
);
  logic [NUM_THREADS-1:0] base_ok;

  commit_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .thr_active (thr_active),
    .thr_status (thr_status),
    .base_ok    (base_ok)
  );

  if (NUM_THREADS == 1) begin : g_single
    assign pick_valid = base_ok[0];
    assign pick_tid   = '0;
  end else begin : g_multi
    logic                   rotate_mode;
    logic [NUM_THREADS-1:0] rr_qual, age_qual;
    logic                   rr_valid, age_valid;
    logic [TID_W-1:0]       rr_tid, age_tid;

    assign rotate_mode = (policy_sel == POL_ROTATE);
    assign rr_qual     = base_ok & head_ready;
    assign age_qual    = base_ok & head_ready & ~rob_empty;

    commit_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rr (
      .clk     (clk),
      .rst_n   (rst_n),
      .qual    (rr_qual),
      .advance (grant & rotate_mode),
      .valid   (rr_valid),
      .tid     (rr_tid)
    );

    commit_age_pick #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
      .qual     (age_qual),
      .head_seq (head_seq),
      .valid    (age_valid),
      .tid      (age_tid)
    );

    assign pick_valid = rotate_mode ? rr_valid : age_valid;
    assign pick_tid   = rotate_mode ? rr_tid   : age_tid;
  end
endmodule

// File: rtl/smt_commit_arbiter_chk.sv
module smt_commit_arbiter_chk #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [1:0]                   policy_sel,
  input logic [NUM_THREADS-1:0]       thr_active,
  input logic [3*NUM_THREADS-1:0]     thr_status,
  input logic [NUM_THREADS-1:0]       rob_empty,
  input logic [NUM_THREADS-1:0]       head_ready,
  input logic [SEQ_W*NUM_THREADS-1:0] head_seq,
  input logic                         grant,
  input logic                         pick_valid,
  input logic [TID_W-1:0]             pick_tid
);
  logic [2:0]             sel_state;
  logic [NUM_THREADS-1:0] ok_q, age_q;
  logic                   older_seen;

  always_comb begin
    sel_state  = thr_status[3*int'(pick_tid) +: 3];
    older_seen = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      ok_q[t]  = thr_active[t] && (thr_status[3*t +: 3] <= 3'd2) && head_ready[t];
      age_q[t] = ok_q[t] && !rob_empty[t];
      if (age_q[t] && head_seq[SEQ_W*t +: SEQ_W] < head_seq[SEQ_W*int'(pick_tid) +: SEQ_W])
        older_seen = 1'b1;
    end
  end

  assert_state_allowed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (sel_state <= 3'd2));

  assert_thread_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> thr_active[pick_tid]);

  if (NUM_THREADS > 1) begin : g_multi_chk
    assert_none_qualify_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_q == '0) |-> (!pick_valid && pick_tid == '0));

    assert_oldest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid && policy_sel != 2'd1) |-> (age_q[pick_tid] && !older_seen));

    assert_rotate_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_sel == 2'd1 && grant && pick_valid && $countones(ok_q) > 1)
      |=> (!($stable(thr_active) && $stable(thr_status) && $stable(head_ready)
             && $stable(policy_sel)) || pick_tid != $past(pick_tid)));
  end
endmodule

bind smt_commit_arbiter smt_commit_arbiter_chk #(
  .NUM_THREADS(NUM_THREADS),
  .SEQ_W(SEQ_W)
) u_chk (.*);

// File: tb/smt_commit_arbiter_bench.sv
`timescale 1ns/1ps
module smt_commit_arbiter_bench;
  localparam int N = 4, SW = 4, TW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]      pol;
  logic [N-1:0]    act, emp, rdy;
  logic [3*N-1:0]  st;
  logic [SW*N-1:0] seq;
  logic            grant;
  logic            pv;
  logic [TW-1:0]   pt;

  smt_commit_arbiter #(.NUM_THREADS(N), .SEQ_W(SW)) u_smt_commit_arbiter (
    .clk(clk), .rst_n(rst_n), .policy_sel(pol), .thr_active(act), .thr_status(st),
    .rob_empty(emp), .head_ready(rdy), .head_seq(seq), .grant(grant),
    .pick_valid(pv), .pick_tid(pt));

  logic       o_act, o_emp, o_rdy, o_pv;
  logic [2:0] o_st;
  logic [3:0] o_seq;
  logic [0:0] o_pt;

  smt_commit_arbiter #(.NUM_THREADS(1), .SEQ_W(4)) u_one (
    .clk(clk), .rst_n(rst_n), .policy_sel(pol), .thr_active(o_act), .thr_status(o_st),
    .rob_empty(o_emp), .head_ready(o_rdy), .head_seq(o_seq), .grant(grant),
    .pick_valid(o_pv), .pick_tid(o_pt));

  int nchk = 0, nbad = 0;
  int order [N];
  logic [31:0] rs = 32'h1234_5678;
  bit done = 0;

  function automatic bit st_ok(input logic [2:0] s);
    return s <= 3'd2;
  endfunction

  task automatic expect_pick(output bit ev, output int et);
    ev = 0; et = 0;
    if (pol == 2'd1) begin
      for (int i = 0; i < N; i++) begin
        int t = order[i];
        if (!ev && act[t] && st_ok(st[3*t +: 3]) && rdy[t]) begin ev = 1; et = t; end
      end
    end else begin
      for (int t = 0; t < N; t++) begin
        if (act[t] && st_ok(st[3*t +: 3]) && !emp[t] && rdy[t] &&
            (!ev || seq[SW*t +: SW] < seq[SW*et +: SW])) begin ev = 1; et = t; end
      end
    end
  endtask

  task automatic check(input string tag, input bit gv, input int gt, input bit ev, input int et);
    nchk++;
    if (gv !== ev || (ev && gt != et) || (!ev && gt != 0)) begin
      nbad++;
      $display("FAIL %s: got valid=%0d tid=%0d, expected valid=%0d tid=%0d", tag, gv, gt, ev, et);
    end
  endtask

  // Called at a negedge with inputs set; checks, models rotation, moves to next negedge
  task automatic step(input string tag);
    bit ev; int et;
    #1;
    expect_pick(ev, et);
    check(tag, pv, int'(pt), ev, et);
    if (grant && ev && pol == 2'd1) begin
      int p = 0;
      for (int i = 0; i < N; i++) if (order[i] == et) p = i;
      for (int i = 0; i < N - 1; i++) if (i >= p) order[i] = order[i+1];
      order[N-1] = et;
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    pol = 2'd1; act = '1; emp = '0; rdy = '1; st = '0; seq = '0; grant = 0;
    o_act = 1; o_emp = 0; o_rdy = 1; o_st = 3'd0; o_seq = 4'd0;
    for (int i = 0; i < N; i++) order[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R6 reset order: thread 0 first
    step("R6 reset order");
    // R7 rotation after grants
    grant = 1; step("R7 grant t0");
    step("R7 grant t1");
    grant = 0; step("R7 no rotate without grant");
    act = 4'b0000; grant = 1; step("R8 grant while invalid");
    act = 4'b1111; grant = 0; step("R7 list kept after invalid grant");
    pol = 2'd2; grant = 1; step("R7 grant in oldest mode");
    pol = 2'd1; grant = 0; step("R7 list kept after oldest-mode grant");
    // R6 empty flag ignored in rotating mode
    emp = '1; step("R6 empty not consulted");
    emp = '0;
    // R2 blocked states
    st = {3'd7, 3'd5, 3'd4, 3'd3}; step("R2 blocked states");
    st = {3'd2, 3'd1, 3'd4, 3'd3}; step("R2 allowed states");
    st = '0;
    // R3 inactive
    act = 4'b0101; rdy = 4'b0011; step("R3 inactive skipped");
    act = '1; rdy = '1;
    // R1 encodings, R4 oldest
    seq = {4'd4, 4'd2, 4'd6, 4'd8};
    pol = 2'd0; step("R1 greedy");
    pol = 2'd2; step("R1 oldest");
    pol = 2'd3; step("R1 code 3");
    emp = 4'b0100; step("R4 empty skipped");
    emp = '0; rdy = 4'b1011; step("R4 not ready skipped");
    rdy = '1;
    // R5 ties
    seq = {4'd5, 4'd5, 4'd5, 4'd5}; step("R5 all tie");
    seq = {4'd7, 4'd3, 4'd3, 4'd9}; step("R5 tie t1 t2");
    // R8 none
    act = '0; step("R8 none active");
    act = '1;

    // R9 single-thread variant
    o_rdy = 0; o_emp = 1; #1; check("R9 ready ignored", o_pv, int'(o_pt), 1, 0);
    o_st = 3'd4; #1; check("R9 blocked state", o_pv, int'(o_pt), 0, 0);
    o_st = 3'd2; o_act = 0; #1; check("R9 inactive", o_pv, int'(o_pt), 0, 0);
    @(negedge clk);

    // Sweep under all policies with random grants
    for (int k = 0; k < 4000; k++) begin
      rs = nxt(rs); pol = rs[1:0]; act = rs[5:2]; emp = rs[9:6]; rdy = rs[13:10];
      grant = rs[14]; seq = rs[30:15];
      rs = nxt(rs); st = rs[11:0];
      step(pol == 2'd1 ? "R6 sweep" : "R4 sweep");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL R7 watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end
endmodule